// File: doc/BRIEF.md
# Bidirectional Cascadable Segment Shift Register

This block is the serial-to-parallel front end of an 80-segment display driver. It holds two 40-stage shift registers. The two registers share one shift clock and advance on its falling edge. Together they present 80 parallel bits to a downstream latch. Bit k of the parallel bus is segment position k+1. The lower half covers positions 1 to 40 and the upper half covers positions 41 to 80.

Each half has its own direction select and two end pins, a low end and a high end. Each end pin is bidirectional and is modelled as separate input, output and output-enable signals. The direction select decides which end takes serial data in and which end drives serial data out.

When the lower half's outgoing end is wired to the upper half's incoming end, the two halves form a single 80-stage chain. The upper half's outgoing end can then feed a further device, so wider panels can be built by cascading. The select pins may be tied low by a pull-down at integration, which selects upward shifting.

Top module: `seg_shift_top`

## Requirements
- R1: While rst_n is low at a falling edge of shift_clk, all 80 stages become 0. The reset is synchronous and active low.
- R2: When a half's dir_sel bit is 0, each falling edge moves every stage of that half one position up. The value on that half's lo_in enters the lowest stage (bit 0 for the lower half, bit 40 for the upper half).
- R3: When a half's dir_sel bit is 1, each falling edge moves every stage of that half one position down. The value on that half's hi_in enters the highest stage (bit 39 for the lower half, bit 79 for the upper half).
- R4: The two halves are steered independently. Index 0 of each per-half port belongs to the lower half and index 1 to the upper half. One half's select never alters the other half's shifting.
- R5: With dir_sel at 0, hi_oe is 1 and lo_oe is 0. With dir_sel at 1, lo_oe is 1 and hi_oe is 0. Exactly one end pin of each half drives at any time.
- R6: The enabled output carries the stage nearest it. With select 0, hi_out is the half's top stage (bit 39 or bit 79). With select 1, lo_out is the half's bottom stage (bit 0 or bit 40). A disabled output drives 0.
- R7: The input of the end pin currently acting as output has no effect on the stored bits.
- R8: With the lower half's hi_out wired to the upper half's lo_in and both selects at 0, the block acts as one 80-stage chain. A bit entering at the lower half's lo_in appears on the upper half's hi_out after 80 falling edges.
- R9: seg_bits bit k holds segment position k+1 at all times, so the whole register contents are visible on the parallel bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; stages advance on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_sel | input | 2 | Per-half direction select: 0 shifts up, 1 shifts down |
| lo_in | input | 2 | Per-half input side of the low-end pin |
| hi_in | input | 2 | Per-half input side of the high-end pin |
| lo_out | output | 2 | Per-half output side of the low-end pin |
| lo_oe | output | 2 | Per-half output enable of the low-end pin |
| hi_out | output | 2 | Per-half output side of the high-end pin |
| hi_oe | output | 2 | Per-half output enable of the high-end pin |
| seg_bits | output | 80 | Parallel stage contents; bit k is position k+1 |

## Verification
The bench drives pseudo-random serial streams in both directions on each half, and sets the halves to opposite directions at the same time. A design that mixes up the per-half selects or the end stages would show shifted or mirrored data on the parallel bus. During each test the bench also toggles the input of the pin acting as output. A design that samples the wrong end would pick up that noise. A full 80-edge cascade run checks that no stage is lost or doubled at the boundary between the halves, which an off-by-one in the boundary would break. The bench also asserts reset in the middle of a stream and expects every stage to clear at that edge, not one edge later.

// File: rtl/seg_shift_pkg.sv
// Shared types for the segment shift register.
// Assumes a select level of 0 is the tie-low default of the pin.
package seg_shift_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,  // serial in at low end, out at high end
        DIR_DOWN = 1'b1   // serial in at high end, out at low end
    } shift_dir_e;
endpackage

// File: rtl/seg_pin_steer.sv
// End-pin steering for one half: picks the driving end from the
// direction and drives the idle end's output low. Purely combinational.
module seg_pin_steer
    import seg_shift_pkg::*;
(
    input  shift_dir_e dir,
    input  logic       bottom_stage,
    input  logic       top_stage,
    output logic       lo_out,
    output logic       lo_oe,
    output logic       hi_out,
    output logic       hi_oe
);
    // Select the driving end and its data.
    always_comb begin
        lo_oe  = (dir == DIR_DOWN);
        hi_oe  = (dir == DIR_UP);
        lo_out = (dir == DIR_DOWN) ? bottom_stage : 1'b0;
        hi_out = (dir == DIR_UP)   ? top_stage    : 1'b0;
    end
endmodule

// File: rtl/seg_half.sv
// One shift-register half of HALF_W stages with steerable serial ends.
// Assumes dir is stable around the falling edge of clk.
module seg_half
    import seg_shift_pkg::*;
#(
    parameter int HALF_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_bit,
    input  logic              lo_in,
    input  logic              hi_in,
    output logic              lo_out,
    output logic              lo_oe,
    output logic              hi_out,
    output logic              hi_oe,
    output logic [HALF_W-1:0] stages
);
    localparam int TOP = HALF_W - 1;

    shift_dir_e        dir;
    logic [HALF_W-1:0] q;

    // Map the raw select bit onto the direction type.
    always_comb dir = shift_dir_e'(dir_bit);

    // Shift on the falling edge; reset clears all stages.
    always_ff @(negedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (dir == DIR_UP)
            q <= {q[TOP-1:0], lo_in};
        else
            q <= {hi_in, q[TOP:1]};
    end

    // Drive the parallel view of the stages.
    always_comb stages = q;

    seg_pin_steer u_steer (
        .dir          (dir),
        .bottom_stage (q[0]),
        .top_stage    (q[TOP]),
        .lo_out       (lo_out),
        .lo_oe        (lo_oe),
        .hi_out       (hi_out),
        .hi_oe        (hi_oe)
    );
endmodule

// File: rtl/seg_shift_top.sv
// Segment shift register built from NUM_HALVES independently steered
// halves sharing one shift clock. Cascading is done by external wiring.
module seg_shift_top #(
    parameter int HALF_W     = 40,
    parameter int NUM_HALVES = 2,
    localparam int SEG_W     = HALF_W * NUM_HALVES
) (
    input  logic                  shift_clk,
    input  logic                  rst_n,
    input  logic [NUM_HALVES-1:0] dir_sel,
    input  logic [NUM_HALVES-1:0] lo_in,
    input  logic [NUM_HALVES-1:0] hi_in,
    output logic [NUM_HALVES-1:0] lo_out,
    output logic [NUM_HALVES-1:0] lo_oe,
    output logic [NUM_HALVES-1:0] hi_out,
    output logic [NUM_HALVES-1:0] hi_oe,
    output logic [SEG_W-1:0]      seg_bits
);
    // One shift-register half per slice of the parallel bus.
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        seg_half #(.HALF_W(HALF_W)) u_half (
            .clk     (shift_clk),
            .rst_n   (rst_n),
            .dir_bit (dir_sel[h]),
            .lo_in   (lo_in[h]),
            .hi_in   (hi_in[h]),
            .lo_out  (lo_out[h]),
            .lo_oe   (lo_oe[h]),
            .hi_out  (hi_out[h]),
            .hi_oe   (hi_oe[h]),
            .stages  (seg_bits[h*HALF_W +: HALF_W])
        );
    end
endmodule

// File: rtl/seg_shift_sva.sv
// Checker for seg_shift_top, sampled on the falling shift edge.
// Assumes the default two-half arrangement.
module seg_shift_sva #(
    parameter int HALF_W = 40,
    localparam int SEG_W = 2 * HALF_W,
    localparam int T0    = HALF_W - 1,
    localparam int B1    = HALF_W,
    localparam int T1    = SEG_W - 1
) (
    input logic             shift_clk,
    input logic             rst_n,
    input logic [1:0]       dir_sel,
    input logic [1:0]       lo_in,
    input logic [1:0]       hi_in,
    input logic [1:0]       lo_oe,
    input logic [1:0]       hi_oe,
    input logic [SEG_W-1:0] seg_bits
);
    AST_RESET_CLEARS: assert property (@(negedge shift_clk) !rst_n |=> seg_bits == '0); // R1
    AST_UP_ENTRY_LO: assert property (@(negedge shift_clk) disable iff (!rst_n)
        (rst_n && !dir_sel[0]) |=> seg_bits[0] == $past(lo_in[0])); // R2
    AST_UP_MOVE_LO: assert property (@(negedge shift_clk) disable iff (!rst_n)
        (rst_n && !dir_sel[0]) |=> seg_bits[T0:1] == $past(seg_bits[T0-1:0])); // R2
    AST_DOWN_ENTRY_LO: assert property (@(negedge shift_clk) disable iff (!rst_n)
        (rst_n && dir_sel[0]) |=> seg_bits[T0] == $past(hi_in[0])); // R3
    AST_DOWN_MOVE_HI: assert property (@(negedge shift_clk) disable iff (!rst_n)
        (rst_n && dir_sel[1]) |=> seg_bits[T1-1:B1] == $past(seg_bits[T1:B1+1])); // R3
    AST_UP_ENTRY_HI: assert property (@(negedge shift_clk) disable iff (!rst_n)
        (rst_n && !dir_sel[1]) |=> seg_bits[B1] == $past(lo_in[1])); // R4
    AST_ONE_DRIVER_LO: assert property (@(negedge shift_clk) disable iff (!rst_n)
        $countones({lo_oe[0], hi_oe[0]}) == 1); // R5
    AST_ONE_DRIVER_HI: assert property (@(negedge shift_clk) disable iff (!rst_n)
        $countones({lo_oe[1], hi_oe[1]}) == 1); // R5
endmodule

bind seg_shift_top seg_shift_sva #(.HALF_W(HALF_W)) u_sva (
    .shift_clk (shift_clk),
    .rst_n     (rst_n),
    .dir_sel   (dir_sel),
    .lo_in     (lo_in),
    .hi_in     (hi_in),
    .lo_oe     (lo_oe),
    .hi_oe     (hi_oe),
    .seg_bits  (seg_bits)
);

// File: tb/tb_seg_shift_top.sv
// Directed bench for seg_shift_top with an independent expected model.
module tb_seg_shift_top;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 40;
    localparam int SW = 80;

    logic          shift_clk = 1'b1;
    logic          rst_n = 1'b0;
    logic [1:0]    dir_sel = 2'b00;
    logic [1:0]    drv_lo = 2'b00;
    logic [1:0]    hi_in = 2'b00;
    logic          cascade = 1'b0;
    logic [1:0]    lo_in;
    logic [1:0]    lo_out, lo_oe, hi_out, hi_oe;
    logic [SW-1:0] seg_bits;
    logic [SW-1:0] exp_bits = '0;
    logic [15:0]   lfsr = 16'hACE1;
    int            checks = 0;
    int            errors = 0;

    always #(CLK_PERIOD/2) shift_clk = ~shift_clk;

    // Upper half input comes from lower half output when cascaded.
    assign lo_in = {cascade ? hi_out[0] : drv_lo[1], drv_lo[0]};

    seg_shift_top dut (
        .shift_clk (shift_clk),
        .rst_n     (rst_n),
        .dir_sel   (dir_sel),
        .lo_in     (lo_in),
        .hi_in     (hi_in),
        .lo_out    (lo_out),
        .lo_oe     (lo_oe),
        .hi_out    (hi_out),
        .hi_oe     (hi_oe),
        .seg_bits  (seg_bits)
    );

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // One falling edge: apply inputs, advance expected model per requirements.
    task automatic step(input logic [1:0] ilo, input logic [1:0] ihi);
        logic [1:0] eff_lo;
        drv_lo = ilo;
        hi_in  = ihi;
        eff_lo = ilo;
        if (cascade) eff_lo[1] = dir_sel[0] ? 1'b0 : exp_bits[HW-1];
        @(negedge shift_clk);
        if (!rst_n) exp_bits = '0;
        else begin
            for (int h = 0; h < 2; h++) begin
                logic [HW-1:0] s;
                s = exp_bits[h*HW +: HW];
                if (!dir_sel[h]) s = {s[HW-2:0], eff_lo[h]};
                else             s = {ihi[h], s[HW-1:1]};
                exp_bits[h*HW +: HW] = s;
            end
        end
        @(posedge shift_clk);
        #1;
    endtask

    // Compare bus and pins with the model.
    task automatic check_state(input string req);
        checks++;
        if (seg_bits !== exp_bits) begin
            errors++;
            $display("FAIL %s seg_bits act=%h exp=%h", req, seg_bits, exp_bits);
        end
        for (int h = 0; h < 2; h++) begin
            logic e_lo_oe, e_hi_oe, e_lo_out, e_hi_out;
            e_hi_oe  = !dir_sel[h];
            e_lo_oe  = dir_sel[h];
            e_hi_out = dir_sel[h] ? 1'b0 : exp_bits[h*HW + HW - 1];
            e_lo_out = dir_sel[h] ? exp_bits[h*HW] : 1'b0;
            checks++;
            if ({lo_oe[h], hi_oe[h]} !== {e_lo_oe, e_hi_oe}) begin
                errors++;
                $display("FAIL R5 half%0d oe act=%b%b exp=%b%b", h, lo_oe[h], hi_oe[h], e_lo_oe, e_hi_oe);
            end
            checks++;
            if ({lo_out[h], hi_out[h]} !== {e_lo_out, e_hi_out}) begin
                errors++;
                $display("FAIL R6 half%0d out act=%b%b exp=%b%b", h, lo_out[h], hi_out[h], e_lo_out, e_hi_out);
            end
        end
    endtask

    task automatic t_reset();  // R1
        rst_n = 1'b0;
        step(2'b11, 2'b11);
        step(2'b11, 2'b11);
        check_state("R1");
        rst_n = 1'b1;
    endtask

    task automatic t_up_both();  // R2, R9, R7: hi_in toggles as noise
        dir_sel = 2'b00;
        for (int i = 0; i < 45; i++) begin
            step({next_rand(), next_rand()}, {next_rand(), next_rand()});
            check_state("R2 R7 R9");
        end
    endtask

    task automatic t_down_both();  // R3, R7: lo_in toggles as noise
        dir_sel = 2'b11;
        for (int i = 0; i < 45; i++) begin
            step({next_rand(), next_rand()}, {next_rand(), next_rand()});
            check_state("R3 R7");
        end
    endtask

    task automatic t_mixed();  // R4: opposite directions at once
        dir_sel = 2'b10;
        for (int i = 0; i < 20; i++) begin
            step({next_rand(), next_rand()}, {next_rand(), next_rand()});
            check_state("R4");
        end
        dir_sel = 2'b01;
        for (int i = 0; i < 20; i++) begin
            step({next_rand(), next_rand()}, {next_rand(), next_rand()});
            check_state("R4");
        end
    endtask

    task automatic t_cascade();  // R8: 80-stage chain, marker bit tracked
        dir_sel = 2'b00;
        cascade = 1'b1;
        rst_n = 1'b0;
        step(2'b00, 2'b00);
        rst_n = 1'b1;
        step(2'b01, 2'b11);
        for (int i = 1; i < SW; i++) begin
            step(2'b00, {next_rand(), next_rand()});
            check_state("R8");
        end
        checks++;
        if (hi_out[1] !== 1'b1) begin
            errors++;
            $display("FAIL R8 chain end act=%b exp=1", hi_out[1]);
        end
        step(2'b00, 2'b00);
        checks++;
        if (hi_out[1] !== 1'b0) begin
            errors++;
            $display("FAIL R8 after marker act=%b exp=0", hi_out[1]);
        end
        cascade = 1'b0;
    endtask

    task automatic t_mid_reset();  // R1 in the middle of a stream
        dir_sel = 2'b00;
        for (int i = 0; i < 10; i++) step(2'b11, 2'b00);
        rst_n = 1'b0;
        step(2'b11, 2'b11);
        check_state("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(posedge shift_clk);
        #1;
        t_reset();
        t_up_both();
        t_down_both();
        t_mixed();
        t_cascade();
        t_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule